// File: doc/BRIEF.md
# Noise-Tolerant Serial Receiver with Majority Voting

This block recovers bytes from an asynchronous serial line whose resting level is high. A separate rate generator supplies a single-cycle tick sixteen times per bit. The receiver resynchronises the line into the clock domain and looks at it only on those ticks. A falling edge does not commit the receiver to a character straight away. The edge opens a qualification period, and a pulse that fails to stay low is thrown away and reported as noise.

Every bit, including the start bit, is decided by a vote over the three samples nearest the centre of its sixteen. This means a single corrupted sample cannot change a bit. After the data bits, the receiver checks an optional parity bit and one or two stop bits. It then presents the byte together with its error flags. A line held low through the whole character is reported as a break, not as a byte. The parity mode and the stop-bit count are static configuration inputs that must only change while the line is idle.

Top module: `uart_rx_vote`

## Requirements
- R1: While reset is asserted and after it is released, rx_data reads 0, and rx_valid, glitch, err_frame, err_parity and brk read 0.
- R2: A start is opened only when a tick sample is low and the previous tick sample was high. That falling-edge sample is sample 0. If fewer than two of samples 7, 8 and 9 are low, the event is dropped. In that case glitch pulses for one cycle right after the tick of sample 9, no character is produced, and the receiver returns to waiting for a new falling edge.
- R3: Every bit value is the majority of its samples 7, 8 and 9. Samples 0 to 6 and 10 to 15 of a bit do not affect it, and a single wrong sample among 7, 8 and 9 is outvoted.
- R4: Eight data bits follow the start bit back to back, each 16 ticks long, and are placed in rx_data with the first received bit in bit 0.
- R5: When par_en is 1, one parity bit follows the data. For even parity (par_odd=0), the XOR of the eight data bits and the parity bit must be 0. For odd parity (par_odd=1), it must be 1. A mismatch sets err_parity. When par_en is 0, err_parity is 0.
- R6: Stop bits follow: one when two_stop=0, two when two_stop=1. A stop bit voted low sets err_frame. A low first stop bit ends the character at that bit.
- R7: rx_valid is a one-cycle pulse in the clock after the tick of sample 15 of the last stop bit examined. rx_data, err_frame, err_parity and brk change only with that pulse and hold until the next one.
- R8: If the data bits, the parity bit (when enabled) and the first stop bit all vote low, the character is reported as a break. The outputs are brk=1, rx_data=0, err_frame=0 and err_parity=0, with the rx_valid pulse after the first stop bit. No further start is accepted until the line is sampled high again.
- R9: rx_valid and glitch never pulse in the same cycle, and each pulses only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx | input | 1 | Asynchronous serial line, high when idle |
| par_en | input | 1 | 1 inserts a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 expects two stop bits, 0 one |
| rx_data | output | 8 | Received byte, first bit in bit 0 |
| rx_valid | output | 1 | One-cycle strobe marking a finished character |
| err_frame | output | 1 | A stop bit voted low |
| err_parity | output | 1 | The parity bit did not match the selected mode |
| brk | output | 1 | The character was a held-low break |
| glitch | output | 1 | One-cycle strobe for a rejected start edge |

## Verification
Random bytes are sent under every mix of parity mode and stop count. In some of these frames, each bit has one flipped sample outside the voting window and one inside it. The flipped samples are what separate a proper three-sample vote from a single-point sample or a vote over the wrong positions. Directed frames with bytes such as 0x01 and 0x80 pin down the bit order. Parity bits are sent both correct and inverted, in both parity modes, and a low second stop bit is sent on its own, so that each error flag is tied to its own cause. Low pulses of 1, 7 and 8 samples must be rejected at sample 9, a fully low character must come out as a break and not as a framing error, and the frame that follows each of these is checked so that the return to idle is confirmed.

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rx,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_valid,
  output logic             err_frame,
  output logic             err_parity,
  output logic             brk,
  output logic             glitch
);
  localparam int BW = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DBITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD} st_t;
  st_t st;

  logic [1:0]       sync;
  logic             rx_s, last, v7, v8, bitv, allz, pbit, maj, perr, endbit;
  logic [3:0]       cnt;
  logic [BW-1:0]    bidx;
  logic [DBITS-1:0] shreg;

  assign rx_s   = sync[1];
  assign maj    = (v7 & v8) | (v7 & rx_s) | (v8 & rx_s);
  assign perr   = par_en & (^shreg ^ pbit ^ par_odd);
  assign endbit = (cnt == 4'd15);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      last       <= 1'b0;
      v7         <= 1'b1;
      v8         <= 1'b1;
      bitv       <= 1'b1;
      allz       <= 1'b1;
      pbit       <= 1'b0;
      cnt        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      brk        <= 1'b0;
      glitch     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      glitch   <= 1'b0;
      if (tick16) begin
        last <= rx_s;
        cnt  <= cnt + 4'd1;
        if (cnt == 4'd7) v7 <= rx_s;
        if (cnt == 4'd8) v8 <= rx_s;
        if (cnt == 4'd9) bitv <= maj;
        case (st)
          S_IDLE: begin
            cnt <= 4'd1;
            if (last && !rx_s) st <= S_START;
          end
          S_START: begin
            if (cnt == 4'd9 && maj) begin
              glitch <= 1'b1;
              st     <= S_IDLE;
            end else if (endbit) begin
              st   <= S_DATA;
              bidx <= '0;
              allz <= 1'b1;
            end
          end
          S_DATA: if (endbit) begin
            shreg <= {bitv, shreg[DBITS-1:1]};
            allz  <= allz & ~bitv;
            bidx  <= bidx + 1'b1;
            if (bidx == LAST_BIT) st <= par_en ? S_PAR : S_STOP1;
          end
          S_PAR: if (endbit) begin
            pbit <= bitv;
            allz <= allz & ~bitv;
            st   <= S_STOP1;
          end
          S_STOP1: if (endbit) begin
            if (!bitv) begin
              rx_valid   <= 1'b1;
              rx_data    <= allz ? '0 : shreg;
              brk        <= allz;
              err_frame  <= ~allz;
              err_parity <= perr & ~allz;
              st         <= allz ? S_HOLD : S_IDLE;
            end else if (two_stop) begin
              st <= S_STOP2;
            end else begin
              rx_valid   <= 1'b1;
              rx_data    <= shreg;
              brk        <= 1'b0;
              err_frame  <= 1'b0;
              err_parity <= perr;
              st         <= S_IDLE;
            end
          end
          S_STOP2: if (endbit) begin
            rx_valid   <= 1'b1;
            rx_data    <= shreg;
            brk        <= 1'b0;
            err_frame  <= ~bitv;
            err_parity <= perr;
            st         <= S_IDLE;
          end
          S_HOLD: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_rx_vote_chk #(
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick16,
  input logic             par_en,
  input logic [DBITS-1:0] rx_data,
  input logic             rx_valid,
  input logic             err_frame,
  input logic             err_parity,
  input logic             brk,
  input logic             glitch
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && glitch));

  a_r9_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || glitch) |-> $past(tick16));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(err_frame) && $stable(err_parity) && $stable(brk)));

  a_r8_break_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && brk) |-> (rx_data == '0 && !err_frame && !err_parity));

  a_r5_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en) |-> !err_parity);
endmodule

bind uart_rx_vote uart_rx_vote_chk #(.DBITS(DBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .par_en(par_en),
  .rx_data(rx_data), .rx_valid(rx_valid), .err_frame(err_frame),
  .err_parity(err_parity), .brk(brk), .glitch(glitch)
);

// File: tb/tb_uart_rx_vote.sv
module tb_uart_rx_vote;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, err_frame, err_parity, brk, glitch;

  uart_rx_vote dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, viol = 0, smpl = 0;
  int got_n = 0, got_idx = -1, gl_n = 0, gl_idx = -1;
  logic [7:0] got_d;
  logic got_fe, got_pe, got_bk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic lv);
    rx = lv; tick16 = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (rx_valid || glitch) viol++;
    end
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
    if (rx_valid && glitch) viol++;
    if (rx_valid) begin
      got_n++; got_idx = smpl; got_d = rx_data;
      got_fe = err_frame; got_pe = err_parity; got_bk = brk;
    end
    if (glitch) begin gl_n++; gl_idx = smpl; end
    smpl++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b1);
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd, input logic flip);
    return ^d ^ odd ^ flip;
  endfunction

  task automatic send_char(input logic [7:0] d, input logic flip, input logic s1,
                           input logic s2, input logic noisy);
    logic bits [12];
    int nb, e, g0, h0, exp_idx, fp, mp;
    logic pb, exp_fe, exp_pe, exp_bk;
    string tag;
    pb = par_bit(d, par_odd, flip);
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    nb = 9;
    if (par_en) begin bits[nb] = pb; nb++; end
    bits[nb] = s1; nb++;
    if (two_stop && s1) begin bits[nb] = s2; nb++; end
    e = smpl; g0 = got_n; h0 = gl_n;
    for (int b = 0; b < nb; b++) begin
      fp = $urandom_range(1, 12);
      if (fp > 6) fp += 3;
      mp = 7 + $urandom_range(0, 2);
      for (int s = 0; s < 16; s++)
        put((noisy && (s == fp || s == mp)) ? !bits[b] : bits[b]);
    end
    idle(20);
    exp_bk = (d == 8'h00) && !s1 && (!par_en || !pb);
    exp_fe = !exp_bk && (!s1 || (two_stop && !s2));
    exp_pe = par_en && flip && !exp_bk;
    exp_idx = e + 16 * nb - 1;
    tag = noisy ? "R3" : "R4";
    chk(got_n == g0 + 1, "R7 count", got_n - g0, 1);
    chk(got_idx == exp_idx, "R7 timing", got_idx, exp_idx);
    chk(got_d == (exp_bk ? 8'h00 : d), tag, got_d, exp_bk ? 0 : d);
    chk(got_pe == exp_pe, "R5 parity flag", got_pe, exp_pe);
    chk(got_fe == exp_fe, "R6 frame flag", got_fe, exp_fe);
    chk(got_bk == exp_bk, "R8 break flag", got_bk, exp_bk);
    chk(gl_n == h0, "R2 no glitch on real start", gl_n - h0, 0);
  endtask

  task automatic send_break();
    int e, g0, h0, endi;
    e = smpl; g0 = got_n; h0 = gl_n;
    endi = e + 16 * (10 + int'(par_en)) - 1;
    for (int i = 0; i < 16 * (10 + int'(par_en)) + 48; i++) put(1'b0);
    chk(got_n == g0 + 1, "R8 single report", got_n - g0, 1);
    chk(got_idx == endi, "R8 report time", got_idx, endi);
    chk(got_bk == 1'b1 && got_fe == 1'b0 && got_pe == 1'b0, "R8 flags",
        {got_bk, got_fe, got_pe}, 3'b100);
    chk(got_d == 8'h00, "R8 data", got_d, 0);
    chk(gl_n == h0, "R8 no glitch while low", gl_n - h0, 0);
    idle(20);
    send_char(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic glitch_low(input int k);
    int e, g0, h0;
    e = smpl; g0 = got_n; h0 = gl_n;
    for (int i = 0; i < k; i++) put(1'b0);
    idle(30);
    chk(gl_n == h0 + 1, "R2 glitch count", gl_n - h0, 1);
    chk(gl_idx == e + 9, "R2 glitch time", gl_idx, e + 9);
    chk(got_n == g0, "R2 no character", got_n - g0, 0);
    send_char(8'h96, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rx_data == 8'h00 && !rx_valid && !glitch && !err_frame && !err_parity && !brk,
        "R1 during reset", {rx_data, rx_valid, glitch, err_frame, err_parity, brk}, 0);
    rst_n = 1'b1;
    idle(20);
    chk(rx_data == 8'h00 && !err_frame && !err_parity && !brk && got_n == 0 && gl_n == 0,
        "R1 after reset", got_n + gl_n, 0);

    send_char(8'hA5, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h01, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h80, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h5A, 1'b0, 1'b1, 1'b1, 1'b1);

    par_en = 1'b1; par_odd = 1'b0;
    send_char(8'h37, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h37, 1'b1, 1'b1, 1'b1, 1'b0);
    par_odd = 1'b1;
    send_char(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'hC3, 1'b1, 1'b1, 1'b1, 1'b0);
    par_en = 1'b0;

    send_char(8'h4E, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(5);
    two_stop = 1'b1;
    send_char(8'h71, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(5);
    send_char(8'h71, 1'b0, 1'b1, 1'b1, 1'b1);
    two_stop = 1'b0;

    send_break();
    par_en = 1'b1; two_stop = 1'b1;
    send_break();
    par_en = 1'b0; two_stop = 1'b0;

    glitch_low(1);
    glitch_low(7);
    glitch_low(8);

    for (int n = 0; n < 60; n++) begin
      par_en   = 1'($urandom_range(0, 1));
      par_odd  = 1'($urandom_range(0, 1));
      two_stop = 1'($urandom_range(0, 1));
      send_char(8'($urandom_range(0, 255)), $urandom_range(0, 3) == 0,
                $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
                1'($urandom_range(0, 1)));
      idle(4);
    end

    chk(viol == 0, "R9 pulse placement", viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule